// File: doc/BRIEF.md
# Test-Port Instruction Register and Decoder

This block holds the 8-bit instruction of an IEEE 1149.1 test access port. The block also holds the two data registers that need no pins of their own: a one-stage bypass register and a 32-bit identification register. The TAP state machine drives it with one-cycle state strobes on the rising edge of TCK. These strobes are test-logic-reset, capture/shift/update of the instruction path, and capture/shift of the data path. Serial data enters on TDI.

The instruction has two parts: a shift stage and a separate active latch. The decoded controls therefore move only when an update is strobed. They tell the surrounding boundary logic how to behave: whether test mode is active, whether outputs are clamped, whether outputs are forced to high impedance, and which cells capture. They also tell it which data register is on the serial path.

On capture the shift stage loads the SAMPLE/PRELOAD opcode. A capture followed directly by an update therefore selects sampling without shifting anything in. A falling-edge TDO stage chooses among the instruction shift stage, the bypass stage, the identification register and the serial output of the external boundary chain.

Top module: `tap_ir_decode`

## Requirements
- R1: After reset or a test-logic-reset strobe, the active opcode is IDCODE (0xAA). The controls then read `dr_sel`=1 with `test_mode`, `clamp_en`, `hiz_en`, `cap_inputs` and `cap_outputs` all 0.
- R2: Capture-IR loads 0x81 into the shift stage. During shift-IR, TDO presents that value LSB first. A capture followed by an update with no shift selects SAMPLE/PRELOAD (0x81): `dr_sel`=2, both capture flags 1, `test_mode` 0.
- R3: Each shift-IR edge moves TDI into the MSB of the shift stage. The decoded controls keep their value until update-IR.
- R4: Four opcodes select the boundary chain (`dr_sel`=2), each with its own flags:
  - 0x00: `test_mode`=1, both capture flags set.
  - 0x41: only `cap_inputs` set.
  - 0x42: only `cap_outputs` set.
  - 0x22: `test_mode`=1 and only `cap_outputs` set.
- R5: Opcode 0x82 gives `clamp_en`=1 and `test_mode`=1, with the bypass stage selected (`dr_sel`=0).
- R6: Opcode 0x03 gives `hiz_en`=1 and `test_mode`=0, with the bypass stage selected (`dr_sel`=0).
- R7: Opcode 0xFF, and every opcode outside the listed set, selects bypass with all mode flags 0.
- R8: When bypass is selected, capture-DR loads 0 into the bypass stage. During shift-DR, TDO then shows that 0 followed by TDI delayed by one cycle.
- R9: When IDCODE is selected, capture-DR loads 0x0FC0001F. The fields are version 0 (bits 31:28), part 0xFC00 (bits 27:12), manufacturer 0x00F (bits 11:1) and bit 0 = 1. Shift-DR presents it LSB first.
- R10: When the boundary chain is selected, TDO during shift-DR follows `bsr_so` as sampled on the falling edge.
- R11: TDO and `tdo_oe` change only on falling TCK edges. `tdo_oe` is 1 exactly while a shift strobe is high, and TDO holds its last value outside shifting.
- R12: When test-logic-reset and update-IR fall in the same cycle, test-logic-reset wins and IDCODE becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tlr | input | 1 | Test-logic-reset state strobe |
| cap_ir | input | 1 | Capture-IR strobe |
| shift_ir | input | 1 | Shift-IR strobe |
| upd_ir | input | 1 | Update-IR strobe |
| cap_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR strobe |
| tdi | input | 1 | Serial test data in |
| bsr_so | input | 1 | Serial output of the external boundary chain |
| tdo | output | 1 | Serial test data out, falling-edge registered |
| tdo_oe | output | 1 | TDO drive enable |
| test_mode | output | 1 | Boundary output cells drive the pins |
| clamp_en | output | 1 | Outputs held from boundary update latches |
| hiz_en | output | 1 | All output enables forced inactive |
| cap_inputs | output | 1 | Input-side boundary cells capture |
| cap_outputs | output | 1 | Output-side boundary cells capture |
| dr_sel | output | 2 | Data register on the path: 0 bypass, 1 identification, 2 boundary |

## Verification
Test-logic-reset and update-IR can be strobed on the same rising edge. That collision is provoked after CLAMP has been shifted in but not yet committed. The controls are then judged on the next cycle: they must show IDCODE rather than CLAMP. The other overlap involves the falling-edge TDO stage: it samples the shift strobe and the register bit of the same cycle, just before the rising edge shifts that register. A scoreboard therefore predicts every TDO bit per shift cycle, for the instruction path, bypass, identification value and boundary pass-through.

// File: rtl/tap_ir_pkg.sv
package tap_ir_pkg;

  localparam int IR_W    = 8;
  localparam int VER_W   = 4;
  localparam int PART_W  = 16;
  localparam int MFR_W   = 11;
  localparam int ID_W    = VER_W + PART_W + MFR_W + 1;
  localparam int SEL_W   = 2;

  typedef logic [IR_W-1:0] opcode_t;

  localparam opcode_t OP_EXTEST  = 8'h00;
  localparam opcode_t OP_SAMPLE  = 8'h81;
  localparam opcode_t OP_CLAMP   = 8'h82;
  localparam opcode_t OP_HIGHZ   = 8'h03;
  localparam opcode_t OP_SMP_IN  = 8'h41;
  localparam opcode_t OP_SMP_OUT = 8'h42;
  localparam opcode_t OP_EXT_OUT = 8'h22;
  localparam opcode_t OP_IDCODE  = 8'hAA;
  localparam opcode_t OP_BYPASS  = 8'hFF;

  typedef enum logic [SEL_W-1:0] {
    DR_BYPASS   = 2'd0,
    DR_IDCODE   = 2'd1,
    DR_BOUNDARY = 2'd2
  } dr_sel_e;

  typedef struct packed {
    logic    test_mode;
    logic    clamp;
    logic    force_hiz;
    logic    cap_in;
    logic    cap_out;
    dr_sel_e dr_sel;
  } ctrl_t;

  // Opcode to control-word mapping; anything unlisted falls to bypass.
  function automatic ctrl_t decode_op(input opcode_t op);
    ctrl_t c;
    c = '{test_mode: 1'b0, clamp: 1'b0, force_hiz: 1'b0,
          cap_in: 1'b0, cap_out: 1'b0, dr_sel: DR_BYPASS};
    case (op)
      OP_EXTEST:  begin c.test_mode = 1'b1; c.cap_in = 1'b1; c.cap_out = 1'b1; c.dr_sel = DR_BOUNDARY; end
      OP_SAMPLE:  begin c.cap_in = 1'b1; c.cap_out = 1'b1; c.dr_sel = DR_BOUNDARY; end
      OP_SMP_IN:  begin c.cap_in = 1'b1; c.dr_sel = DR_BOUNDARY; end
      OP_SMP_OUT: begin c.cap_out = 1'b1; c.dr_sel = DR_BOUNDARY; end
      OP_EXT_OUT: begin c.test_mode = 1'b1; c.cap_out = 1'b1; c.dr_sel = DR_BOUNDARY; end
      OP_CLAMP:   begin c.test_mode = 1'b1; c.clamp = 1'b1; end
      OP_HIGHZ:   begin c.force_hiz = 1'b1; end
      OP_IDCODE:  begin c.dr_sel = DR_IDCODE; end
      default:    ;
    endcase
    return c;
  endfunction

  // Identification word: version, part, manufacturer, then the fixed 1.
  function automatic logic [ID_W-1:0] make_idcode(input logic [VER_W-1:0]  ver,
                                                  input logic [PART_W-1:0] part,
                                                  input logic [MFR_W-1:0]  mfr);
    return {ver, part, mfr, 1'b1};
  endfunction

endpackage

// File: rtl/tap_shift_reg.sv
module tap_shift_reg #(
  parameter int W = 8
) (
  input  logic         tck,
  input  logic         rst_n,
  input  logic         cap,
  input  logic         shift,
  input  logic         tdi,
  input  logic [W-1:0] cap_val,
  output logic [W-1:0] q
);
  logic [W-1:0] shifted;

  generate
    if (W == 1) begin : g_single
      assign shifted = tdi;
    end else begin : g_multi
      assign shifted = {tdi, q[W-1:1]};
    end
  endgenerate

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (cap)   q <= cap_val;
    else if (shift) q <= shifted;
  end
endmodule

// File: rtl/tap_ir_latch.sv
module tap_ir_latch
  import tap_ir_pkg::*;
(
  input  logic    tck,
  input  logic    rst_n,
  input  logic    tlr,
  input  logic    upd,
  input  opcode_t sr_q,
  output opcode_t active_q
);
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)   active_q <= OP_IDCODE;
    else if (tlr) active_q <= OP_IDCODE;
    else if (upd) active_q <= sr_q;
  end
endmodule

// File: rtl/tap_tdo_mux.sv
module tap_tdo_mux
  import tap_ir_pkg::*;
(
  input  logic    tck,
  input  logic    rst_n,
  input  logic    shift_ir,
  input  logic    shift_dr,
  input  logic    ir_bit,
  input  logic    byp_bit,
  input  logic    id_bit,
  input  logic    bsr_bit,
  input  dr_sel_e sel,
  output logic    tdo,
  output logic    tdo_oe
);
  logic dr_bit;

  always_comb begin
    case (sel)
      DR_IDCODE:   dr_bit = id_bit;
      DR_BOUNDARY: dr_bit = bsr_bit;
      default:     dr_bit = byp_bit;
    endcase
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= shift_ir | shift_dr;
      if (shift_ir)      tdo <= ir_bit;
      else if (shift_dr) tdo <= dr_bit;
    end
  end
endmodule

// File: rtl/tap_ir_decode.sv
module tap_ir_decode
  import tap_ir_pkg::*;
#(
  parameter logic [VER_W-1:0]  ID_VERSION = 4'h0,
  parameter logic [PART_W-1:0] ID_PART    = 16'hFC00,
  parameter logic [MFR_W-1:0]  ID_MFR     = 11'h00F
) (
  input  logic             tck,
  input  logic             rst_n,
  input  logic             tlr,
  input  logic             cap_ir,
  input  logic             shift_ir,
  input  logic             upd_ir,
  input  logic             cap_dr,
  input  logic             shift_dr,
  input  logic             tdi,
  input  logic             bsr_so,
  output logic             tdo,
  output logic             tdo_oe,
  output logic             test_mode,
  output logic             clamp_en,
  output logic             hiz_en,
  output logic             cap_inputs,
  output logic             cap_outputs,
  output logic [SEL_W-1:0] dr_sel
);
  localparam logic [ID_W-1:0] ID_VALUE = make_idcode(ID_VERSION, ID_PART, ID_MFR);

  opcode_t         ir_sr;
  opcode_t         ir_active;
  ctrl_t           ctrl;
  logic [0:0]      byp_q;
  logic [ID_W-1:0] id_q;
  logic            byp_cap, byp_shift, id_cap, id_shift;

  // Instruction shift stage: capture loads the sampling opcode.
  tap_shift_reg #(.W(IR_W)) u_ir_sr (
    .tck(tck), .rst_n(rst_n), .cap(cap_ir), .shift(shift_ir),
    .tdi(tdi), .cap_val(OP_SAMPLE), .q(ir_sr)
  );

  tap_ir_latch u_ir_latch (
    .tck(tck), .rst_n(rst_n), .tlr(tlr), .upd(upd_ir),
    .sr_q(ir_sr), .active_q(ir_active)
  );

  always_comb ctrl = decode_op(ir_active);

  // Only the selected data register captures and shifts.
  assign byp_cap   = cap_dr   & (ctrl.dr_sel == DR_BYPASS);
  assign byp_shift = shift_dr & (ctrl.dr_sel == DR_BYPASS);
  assign id_cap    = cap_dr   & (ctrl.dr_sel == DR_IDCODE);
  assign id_shift  = shift_dr & (ctrl.dr_sel == DR_IDCODE);

  tap_shift_reg #(.W(1)) u_bypass (
    .tck(tck), .rst_n(rst_n), .cap(byp_cap), .shift(byp_shift),
    .tdi(tdi), .cap_val(1'b0), .q(byp_q)
  );

  tap_shift_reg #(.W(ID_W)) u_idreg (
    .tck(tck), .rst_n(rst_n), .cap(id_cap), .shift(id_shift),
    .tdi(tdi), .cap_val(ID_VALUE), .q(id_q)
  );

  tap_tdo_mux u_tdo (
    .tck(tck), .rst_n(rst_n), .shift_ir(shift_ir), .shift_dr(shift_dr),
    .ir_bit(ir_sr[0]), .byp_bit(byp_q[0]), .id_bit(id_q[0]), .bsr_bit(bsr_so),
    .sel(ctrl.dr_sel), .tdo(tdo), .tdo_oe(tdo_oe)
  );

  assign test_mode   = ctrl.test_mode;
  assign clamp_en    = ctrl.clamp;
  assign hiz_en      = ctrl.force_hiz;
  assign cap_inputs  = ctrl.cap_in;
  assign cap_outputs = ctrl.cap_out;
  assign dr_sel      = ctrl.dr_sel;
endmodule

// File: rtl/tap_ir_decode_chk.sv
module tap_ir_decode_chk
  import tap_ir_pkg::*;
(
  input logic             tck,
  input logic             rst_n,
  input logic             tlr,
  input logic             cap_ir,
  input logic             shift_ir,
  input logic             upd_ir,
  input logic             cap_dr,
  input logic             shift_dr,
  input logic [IR_W-1:0]  ir_sr,
  input logic [IR_W-1:0]  ir_active,
  input logic [0:0]       byp_q,
  input logic [ID_W-1:0]  id_q,
  input logic             tdo_oe,
  input logic             test_mode,
  input logic             clamp_en,
  input logic             hiz_en,
  input logic [SEL_W-1:0] dr_sel
);
  // R2
  ir_capture_chk: assert property (@(posedge tck) disable iff (!rst_n)
    cap_ir |=> ir_sr == OP_SAMPLE);

  // R1
  tlr_default_chk: assert property (@(posedge tck) disable iff (!rst_n)
    tlr |=> ir_active == OP_IDCODE);

  // R3
  hold_until_update_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (!upd_ir && !tlr) |=> $stable(ir_active));

  // R12
  tlr_over_update_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (tlr && upd_ir) |=> ir_active == OP_IDCODE);

  // R5
  mode_exclusive_chk: assert property (@(posedge tck) disable iff (!rst_n)
    $onehot0({clamp_en, hiz_en}));

  // R6
  hiz_no_test_chk: assert property (@(posedge tck) disable iff (!rst_n)
    hiz_en |-> !test_mode);

  // R8
  bypass_zero_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (cap_dr && dr_sel == 2'd0) |=> byp_q == 1'b0);

  // R9
  idcode_capture_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (cap_dr && dr_sel == 2'd1) |=> id_q == 32'h0FC0_001F);

  // R11
  tdo_enable_chk: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe == (shift_ir || shift_dr));
endmodule

bind tap_ir_decode tap_ir_decode_chk u_chk (
  .tck(tck), .rst_n(rst_n), .tlr(tlr), .cap_ir(cap_ir), .shift_ir(shift_ir),
  .upd_ir(upd_ir), .cap_dr(cap_dr), .shift_dr(shift_dr), .ir_sr(ir_sr),
  .ir_active(ir_active), .byp_q(byp_q), .id_q(id_q), .tdo_oe(tdo_oe),
  .test_mode(test_mode), .clamp_en(clamp_en), .hiz_en(hiz_en), .dr_sel(dr_sel)
);

// File: tb/tap_ir_decode_test.sv
module tap_ir_decode_test;
  logic tck = 1'b0;
  logic rst_n = 1'b0;
  logic tlr = 0, cap_ir = 0, shift_ir = 0, upd_ir = 0, cap_dr = 0, shift_dr = 0;
  logic tdi = 0, bsr_so = 0;
  logic tdo, tdo_oe, test_mode, clamp_en, hiz_en, cap_inputs, cap_outputs;
  logic [1:0] dr_sel;

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  localparam logic [5:0] S_IDLE = 6'b000000;
  localparam logic [5:0] S_TLR  = 6'b100000;
  localparam logic [5:0] S_CIR  = 6'b010000;
  localparam logic [5:0] S_SIR  = 6'b001000;
  localparam logic [5:0] S_UIR  = 6'b000100;
  localparam logic [5:0] S_CDR  = 6'b000010;
  localparam logic [5:0] S_SDR  = 6'b000001;
  localparam logic [31:0] EXP_ID = {4'h0, 16'hFC00, 11'h00F, 1'b1};

  typedef struct { logic b; string tag; } item_t;
  item_t sbq[$];

  always #10 tck = ~tck;

  tap_ir_decode uut (
    .tck(tck), .rst_n(rst_n), .tlr(tlr), .cap_ir(cap_ir), .shift_ir(shift_ir),
    .upd_ir(upd_ir), .cap_dr(cap_dr), .shift_dr(shift_dr), .tdi(tdi),
    .bsr_so(bsr_so), .tdo(tdo), .tdo_oe(tdo_oe), .test_mode(test_mode),
    .clamp_en(clamp_en), .hiz_en(hiz_en), .cap_inputs(cap_inputs),
    .cap_outputs(cap_outputs), .dr_sel(dr_sel)
  );

  // Expected {test, clamp, hiz, cap_in, cap_out, sel[1:0]} per opcode.
  function automatic logic [6:0] exp_modes(input logic [7:0] op);
    case (op)
      8'h00:   return 7'b1_0_0_1_1_10;
      8'h81:   return 7'b0_0_0_1_1_10;
      8'h41:   return 7'b0_0_0_1_0_10;
      8'h42:   return 7'b0_0_0_0_1_10;
      8'h22:   return 7'b1_0_0_0_1_10;
      8'h82:   return 7'b1_1_0_0_0_00;
      8'h03:   return 7'b0_0_1_0_0_00;
      8'hAA:   return 7'b0_0_0_0_0_01;
      default: return 7'b0_0_0_0_0_00;
    endcase
  endfunction

  task automatic step(input logic [5:0] s, input logic d, input logic b);
    @(posedge tck);
    #2;
    {tlr, cap_ir, shift_ir, upd_ir, cap_dr, shift_dr} = s;
    tdi = d;
    bsr_so = b;
  endtask

  task automatic check_modes(input string tag, input logic [7:0] op);
    logic [6:0] act;
    act = {test_mode, clamp_en, hiz_en, cap_inputs, cap_outputs, dr_sel};
    n_tests++;
    if (act !== exp_modes(op)) begin
      n_fail++;
      $display("FAIL %s modes for op %02h: actual %b expected %b", tag, op, act, exp_modes(op));
    end
  endtask

  task automatic check_oe_idle(input string tag);
    @(negedge tck);
    #2;
    n_tests++;
    if (tdo_oe !== 1'b0) begin
      n_fail++;
      $display("FAIL %s tdo_oe after shift: actual %b expected 0", tag, tdo_oe);
    end
  endtask

  // Capture, shift op in (expecting captured 0x81 out), exit.
  task automatic scan_ir(input logic [7:0] op);
    step(S_CIR, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) begin
      sbq.push_back('{b: OP81[i], tag: "R2"});
      step(S_SIR, op[i], 1'b0);
    end
    step(S_IDLE, 1'b0, 1'b0);
  endtask
  localparam logic [7:0] OP81 = 8'h81;

  task automatic update_ir(input logic with_tlr);
    step(with_tlr ? (S_UIR | S_TLR) : S_UIR, 1'b0, 1'b0);
    step(S_IDLE, 1'b0, 1'b0);
  endtask

  task automatic load_op(input logic [7:0] op, input logic [7:0] prev, input string tag);
    scan_ir(op);
    check_modes("R3", prev);
    check_oe_idle("R11");
    update_ir(1'b0);
    check_modes(tag, op);
  endtask

  task automatic scan_bypass(input logic [7:0] pat);
    step(S_CDR, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) begin
      sbq.push_back('{b: (i == 0) ? 1'b0 : pat[i-1], tag: "R8"});
      step(S_SDR, pat[i], 1'b0);
    end
    step(S_IDLE, 1'b0, 1'b0);
  endtask

  task automatic scan_id();
    step(S_CDR, 1'b0, 1'b0);
    for (int i = 0; i < 32; i++) begin
      sbq.push_back('{b: EXP_ID[i], tag: "R9"});
      step(S_SDR, 1'b1, 1'b0);
    end
    step(S_IDLE, 1'b0, 1'b0);
  endtask

  task automatic scan_bsr(input logic [7:0] pat);
    step(S_CDR, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) begin
      sbq.push_back('{b: pat[i], tag: "R10"});
      step(S_SDR, 1'b0, pat[i]);
    end
    step(S_IDLE, 1'b0, 1'b0);
  endtask

  // Monitor: compare each falling-edge TDO bit with the scoreboard.
  initial begin
    forever begin
      @(negedge tck);
      #2;
      if (rst_n && tdo_oe) begin
        n_tests++;
        if (sbq.size() == 0) begin
          n_fail++;
          $display("FAIL R11 unexpected shift bit: actual %b expected none", tdo);
        end else begin
          item_t it;
          it = sbq.pop_front();
          if (tdo !== it.b) begin
            n_fail++;
            $display("FAIL %s tdo bit: actual %b expected %b", it.tag, tdo, it.b);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge tck);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge tck);
    #2 rst_n = 1'b1;
    step(S_IDLE, 1'b0, 1'b0);
    check_modes("R1", 8'hAA);
    check_oe_idle("R1");

    scan_id();
    check_oe_idle("R11");

    // Capture-exit-update with no shift selects sampling.
    step(S_CIR, 1'b0, 1'b0);
    step(S_IDLE, 1'b0, 1'b0);
    update_ir(1'b0);
    check_modes("R2", 8'h81);

    load_op(8'h41, 8'h81, "R4");
    scan_bsr(8'hB4);
    load_op(8'h00, 8'h41, "R4");
    load_op(8'h42, 8'h00, "R4");
    load_op(8'h22, 8'h42, "R4");
    scan_bsr(8'h3C);
    load_op(8'h82, 8'h22, "R5");
    scan_bypass(8'h96);
    load_op(8'h03, 8'h82, "R6");
    load_op(8'hFF, 8'h03, "R7");
    scan_bypass(8'h5B);
    load_op(8'h5A, 8'hFF, "R7");
    load_op(8'hAA, 8'h5A, "R9");
    scan_id();

    // Plain test-logic-reset after CLAMP.
    load_op(8'h82, 8'hAA, "R5");
    step(S_TLR, 1'b0, 1'b0);
    step(S_IDLE, 1'b0, 1'b0);
    check_modes("R1", 8'hAA);

    // Collision: update of CLAMP and test-logic-reset on the same edge.
    scan_ir(8'h82);
    update_ir(1'b1);
    check_modes("R12", 8'hAA);

    repeat (3) step(S_IDLE, 1'b0, 1'b0);
    n_tests++;
    if (sbq.size() != 0) begin
      n_fail++;
      $display("FAIL R11 unconsumed shift bits: actual %0d expected 0", sbq.size());
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule